// File: doc/BRIEF.md
# SPI Flash Block-Erase Sequencer

This block is a host-side controller that erases a single 32 KiB or 64 KiB block of an external SPI serial flash. A one-cycle start request supplies a 24-bit byte address and a size select. The controller then runs a fixed sequence of three phases. First it sends a one-byte write-enable frame. Second it sends a four-byte frame that holds the erase opcode and the block address. Third it sends repeated status-read frames until the flash reports that it is no longer busy.

The erase itself is timed inside the flash, so the controller only watches the busy flag. Bit 0 of each status byte is that flag. The controller stops polling when the flag reads zero, or when a programmable number of polls have all returned busy. Either way it raises a one-cycle done pulse, and a timeout flag marks the second case. The serial clock is derived from the system clock by a programmable divider. The interface uses SPI mode 0: the clock idles low, data out changes on the falling edge, and data in is sampled on the rising edge. Chip select stays high for a programmable minimum number of cycles between frames.

Top module: `spi_block_eraser`

## Requirements
- R1: After reset, cs_n_o is 1, sck_o is 0, and busy_o, done_o and timeout_o are 0.
- R2: The first frame of every sequence is a chip-select frame of exactly 8 clocks carrying the byte 0x06, MSB first.
- R3: The second frame is exactly 32 clocks long. Its first byte is the erase opcode: 0x52 when size64_i=0 (32 KiB) and 0xD8 when size64_i=1 (64 KiB).
- R4: The last 24 bits of the erase frame are the address, MSB first. Bits 14..0 are forced to 0 for a 32 KiB erase and bits 15..0 are forced to 0 for a 64 KiB erase. The higher bits are copied from addr_i.
- R5: After the erase frame, each poll is a 16-clock frame. It sends 0x05 and then reads one status byte, MSB first, sampled on rising SCK edges. A new poll follows only while status bit 0 (busy) is 1.
- R6: busy_o is 1 from the cycle after an accepted start until done_o. When a poll returns busy=0, done_o pulses for exactly one cycle with timeout_o=0, and busy_o then drops.
- R7: If MAX_POLLS consecutive polls all return busy=1, no further poll is sent, and done_o pulses with timeout_o=1 in the same cycle.
- R8: Chip select stays high for at least CS_GAP system cycles between frames, and sck_o is 0 whenever cs_n_o is 1.
- R9: SPI mode 0: mosi_o only changes while sck_o is low, and each SCK high phase lasts CLK_DIV system cycles.
- R10: miso_i is ignored outside the status byte of a poll frame. Arbitrary levels on it change neither the frames sent nor the outcome.
- R11: A start request that arrives while busy_o is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to erase a block |
| addr_i | input | 24 | Byte address inside the block to erase |
| size64_i | input | 1 | 1 = 64 KiB block, 0 = 32 KiB block |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| timeout_o | output | 1 | Valid with done_o: poll limit reached |
| sck_o | output | 1 | SPI serial clock (idles low) |
| cs_n_o | output | 1 | SPI chip select, active low |
| mosi_o | output | 1 | SPI data to the flash |
| miso_i | input | 1 | SPI data from the flash |

## Verification
Random addresses with random size selects show whether the opcode is chosen correctly and whether the mask is applied at the 15-bit or the 16-bit boundary. All-ones and all-zero addresses are included, so that a mask off by one bit shows up at once. The flash model returns busy for a random number of polls (zero, a few, or at least the limit). These counts separate an early exit, a missing repeat and the timeout path. Garbage is driven on MISO outside the status byte, and a second start is injected mid-sequence, to show that neither disturbs the frames or the result.

// File: rtl/spi_erase_pkg.sv
package spi_erase_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_XFER, ST_GAP} seq_state_t;
  typedef enum logic [1:0] {FR_WREN, FR_ERASE, FR_POLL} frame_kind_t;

  localparam logic [7:0] OP_WR_ENABLE = 8'h06;
  localparam logic [7:0] OP_RD_STATUS = 8'h05;
  localparam logic [7:0] OP_ERASE_32K = 8'h52;
  localparam logic [7:0] OP_ERASE_64K = 8'hD8;

  // Keep only the block-select bits of a byte address.
  function automatic logic [23:0] block_mask(input logic big);
    return big ? 24'hFF_0000 : 24'hFF_8000;
  endfunction
endpackage

// File: rtl/spi_byte_engine.sv
// Shifts one byte out MSB first in SPI mode 0 and keeps the last bit sampled.
module spi_byte_engine #(
  parameter int CLK_DIV = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       go_i,
  input  logic [7:0] tx_i,
  input  logic       miso_i,
  output logic       sck_o,
  output logic       mosi_o,
  output logic       rx_bit_o,
  output logic       byte_done_o
);
  localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  logic [DIV_W-1:0] div_cnt;
  logic [7:0]       shreg;
  logic [2:0]       bit_cnt;
  logic             active;

  always_ff @(posedge clk) begin
    byte_done_o <= 1'b0;
    if (rst) begin
      div_cnt  <= '0;
      shreg    <= '0;
      bit_cnt  <= '0;
      active   <= 1'b0;
      sck_o    <= 1'b0;
      mosi_o   <= 1'b0;
      rx_bit_o <= 1'b0;
    end else if (go_i) begin
      active  <= 1'b1;
      shreg   <= tx_i;
      mosi_o  <= tx_i[7];
      div_cnt <= '0;
      bit_cnt <= '0;
      sck_o   <= 1'b0;
    end else if (active) begin
      if (div_cnt == DIV_W'(CLK_DIV - 1)) begin
        div_cnt <= '0;
        sck_o   <= ~sck_o;
        if (!sck_o) begin
          rx_bit_o <= miso_i;                 // rising edge: sample
        end else begin
          bit_cnt <= bit_cnt + 3'd1;          // falling edge: advance
          if (bit_cnt == 3'd7) begin
            active      <= 1'b0;
            byte_done_o <= 1'b1;
          end else begin
            shreg  <= {shreg[6:0], 1'b0};
            mosi_o <= shreg[6];
          end
        end
      end else begin
        div_cnt <= div_cnt + DIV_W'(1);
      end
    end
  end
endmodule

// File: rtl/cs_gap_timer.sv
// Emits a one-cycle pulse CS_GAP cycles after a load pulse.
module cs_gap_timer #(
  parameter int CS_GAP = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic load_i,
  output logic expired_o
);
  localparam int CW = (CS_GAP > 1) ? $clog2(CS_GAP) : 1;

  logic [CW-1:0] cnt;
  logic          running;

  always_ff @(posedge clk) begin
    expired_o <= 1'b0;
    if (rst) begin
      cnt     <= '0;
      running <= 1'b0;
    end else if (load_i) begin
      cnt     <= CW'(CS_GAP - 1);
      running <= 1'b1;
    end else if (running) begin
      if (cnt == '0) begin
        running   <= 1'b0;
        expired_o <= 1'b1;
      end else begin
        cnt <= cnt - CW'(1);
      end
    end
  end
endmodule

// File: rtl/spi_block_eraser.sv
module spi_block_eraser
  import spi_erase_pkg::*;
#(
  parameter int CLK_DIV   = 4,
  parameter int CS_GAP    = 8,
  parameter int MAX_POLLS = 200000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start_i,
  input  logic [23:0] addr_i,
  input  logic        size64_i,
  output logic        busy_o,
  output logic        done_o,
  output logic        timeout_o,
  output logic        sck_o,
  output logic        cs_n_o,
  output logic        mosi_o,
  input  logic        miso_i
);
  localparam int PW = $clog2(MAX_POLLS + 1);

  seq_state_t  state;
  frame_kind_t frame;
  logic [1:0]  byte_idx;
  logic [1:0]  last_idx;
  logic [23:0] addr_q;
  logic        big_q;
  logic [PW-1:0] poll_cnt;
  logic        finish_q;
  logic        tout_q;
  logic        go;
  logic [7:0]  tx_byte;
  logic        rx_bit;
  logic        byte_done;
  logic        gap_load;
  logic        gap_exp;

  spi_byte_engine #(.CLK_DIV(CLK_DIV)) u_engine (
    .clk(clk), .rst(rst), .go_i(go), .tx_i(tx_byte), .miso_i(miso_i),
    .sck_o(sck_o), .mosi_o(mosi_o), .rx_bit_o(rx_bit), .byte_done_o(byte_done)
  );

  cs_gap_timer #(.CS_GAP(CS_GAP)) u_gap (
    .clk(clk), .rst(rst), .load_i(gap_load), .expired_o(gap_exp)
  );

  // Byte to send for the current frame and position.
  always_comb begin
    tx_byte  = 8'h00;
    last_idx = 2'd0;
    case (frame)
      FR_WREN: tx_byte = OP_WR_ENABLE;
      FR_ERASE: begin
        last_idx = 2'd3;
        case (byte_idx)
          2'd0: tx_byte = big_q ? OP_ERASE_64K : OP_ERASE_32K;
          2'd1: tx_byte = addr_q[23:16];
          2'd2: tx_byte = addr_q[15:8];
          default: tx_byte = addr_q[7:0];
        endcase
      end
      FR_POLL: begin
        last_idx = 2'd1;
        tx_byte  = (byte_idx == 2'd0) ? OP_RD_STATUS : 8'h00;
      end
      default: tx_byte = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    go        <= 1'b0;
    gap_load  <= 1'b0;
    done_o    <= 1'b0;
    timeout_o <= 1'b0;
    if (rst) begin
      state    <= ST_IDLE;
      frame    <= FR_WREN;
      byte_idx <= '0;
      addr_q   <= '0;
      big_q    <= 1'b0;
      poll_cnt <= '0;
      finish_q <= 1'b0;
      tout_q   <= 1'b0;
      busy_o   <= 1'b0;
      cs_n_o   <= 1'b1;
    end else begin
      case (state)
        ST_IDLE: if (start_i) begin
          addr_q   <= addr_i & block_mask(size64_i);
          big_q    <= size64_i;
          frame    <= FR_WREN;
          byte_idx <= '0;
          poll_cnt <= '0;
          finish_q <= 1'b0;
          tout_q   <= 1'b0;
          busy_o   <= 1'b1;
          state    <= ST_SETUP;
        end
        ST_SETUP: begin
          cs_n_o <= 1'b0;
          go     <= 1'b1;
          state  <= ST_XFER;
        end
        ST_XFER: if (byte_done) begin
          if (byte_idx == last_idx) begin
            cs_n_o   <= 1'b1;
            gap_load <= 1'b1;
            state    <= ST_GAP;
            if (frame == FR_POLL) begin
              poll_cnt <= poll_cnt + PW'(1);
              if (!rx_bit) begin
                finish_q <= 1'b1;
              end else if (poll_cnt == PW'(MAX_POLLS - 1)) begin
                finish_q <= 1'b1;
                tout_q   <= 1'b1;
              end
            end
          end else begin
            byte_idx <= byte_idx + 2'd1;
            go       <= 1'b1;
          end
        end
        ST_GAP: if (gap_exp) begin
          if (finish_q) begin
            done_o    <= 1'b1;
            timeout_o <= tout_q;
            busy_o    <= 1'b0;
            state     <= ST_IDLE;
          end else begin
            byte_idx <= '0;
            frame    <= (frame == FR_WREN) ? FR_ERASE : FR_POLL;
            state    <= ST_SETUP;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_block_eraser_chk.sv
module spi_block_eraser_chk #(
  parameter int CS_GAP = 8
) (
  input logic clk,
  input logic rst,
  input logic busy_o,
  input logic done_o,
  input logic timeout_o,
  input logic sck_o,
  input logic cs_n_o,
  input logic mosi_o
);
  localparam int GW = $clog2(CS_GAP + 2);
  logic [GW-1:0] gap_cnt;

  // High-time counter for chip select, saturating at CS_GAP.
  always_ff @(posedge clk) begin
    if (rst) gap_cnt <= GW'(CS_GAP);
    else if (!cs_n_o) gap_cnt <= '0;
    else if (gap_cnt < GW'(CS_GAP)) gap_cnt <= gap_cnt + GW'(1);
  end

  assert_cs_high_when_idle_R6: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> cs_n_o);
  assert_done_single_cycle_R6: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  assert_timeout_with_done_R7: assert property (@(posedge clk) disable iff (rst)
    timeout_o |-> done_o);
  assert_sck_low_deselected_R8: assert property (@(posedge clk) disable iff (rst)
    cs_n_o |-> !sck_o);
  assert_cs_gap_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n_o) |-> gap_cnt >= GW'(CS_GAP));
  assert_mosi_stable_high_sck_R9: assert property (@(posedge clk) disable iff (rst)
    sck_o |-> $stable(mosi_o));
endmodule

bind spi_block_eraser spi_block_eraser_chk #(.CS_GAP(CS_GAP)) u_chk (
  .clk(clk), .rst(rst), .busy_o(busy_o), .done_o(done_o), .timeout_o(timeout_o),
  .sck_o(sck_o), .cs_n_o(cs_n_o), .mosi_o(mosi_o)
);

// File: tb/spi_block_eraser_tb.sv
module spi_block_eraser_tb;
  localparam int CLK_DIV   = 2;
  localparam int CS_GAP    = 3;
  localparam int MAX_POLLS = 5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [23:0] addr_i = '0;
  logic        size64_i = 1'b0;
  logic        busy_o, done_o, timeout_o, sck_o, cs_n_o, mosi_o;
  logic        miso_i = 1'b0;

  spi_block_eraser #(.CLK_DIV(CLK_DIV), .CS_GAP(CS_GAP), .MAX_POLLS(MAX_POLLS)) u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .addr_i(addr_i), .size64_i(size64_i),
    .busy_o(busy_o), .done_o(done_o), .timeout_o(timeout_o),
    .sck_o(sck_o), .cs_n_o(cs_n_o), .mosi_o(mosi_o), .miso_i(miso_i)
  );

  always #5 clk = ~clk;

  int n_total = 0;
  int n_pass  = 0;
  int cyc     = 0;

  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_total++;
    if (ok) n_pass++;
    else $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
  endtask

  // ---------------- flash model ----------------
  logic [63:0] cur_bits;
  int          cur_n;
  logic [63:0] fr_bits [0:15];
  int          fr_n    [0:15];
  int          fr_cnt;
  int          busy_left;
  logic [7:0]  stat;
  int          rise_cyc, cs_rise_cyc;
  int          min_gap;
  int          sck_bad;
  int          done_cnt;
  bit          last_tout;

  always @(negedge cs_n_o) begin
    if (cyc - cs_rise_cyc < min_gap) min_gap = cyc - cs_rise_cyc;
    cur_n    = 0;
    cur_bits = '0;
    miso_i  <= 1'($urandom);
  end

  always @(posedge cs_n_o) begin
    cs_rise_cyc = cyc;
    if (cur_n > 0 && fr_cnt < 16) begin
      fr_bits[fr_cnt] = cur_bits;
      fr_n[fr_cnt]    = cur_n;
      fr_cnt++;
    end
  end

  always @(posedge sck_o) begin
    rise_cyc = cyc;
    if (!cs_n_o) begin
      cur_bits = {cur_bits[62:0], mosi_o};
      cur_n++;
      if (cur_n == 8 && cur_bits[7:0] == 8'h05) begin
        stat = {7'($urandom), busy_left > 0};
        if (busy_left > 0) busy_left--;
      end
    end
  end

  always @(negedge sck_o) begin
    if (cyc - rise_cyc != CLK_DIV) sck_bad++;
    if (cur_n >= 8 && cur_n < 16) miso_i <= stat[15 - cur_n];
    else miso_i <= 1'($urandom);      // garbage outside status byte (R10)
  end

  always @(posedge clk) if (done_o) begin
    done_cnt++;
    last_tout = timeout_o;
  end

  // ---------------- expectations ----------------
  function automatic logic [31:0] exp_erase(input logic [23:0] a, input logic big);
    logic [23:0] m;
    m = big ? {a[23:16], 16'h0} : {a[23:15], 15'h0};
    return {big ? 8'hD8 : 8'h52, m};
  endfunction

  function automatic int exp_polls(input int b);
    return (b >= MAX_POLLS) ? MAX_POLLS : b + 1;
  endfunction

  task automatic run_erase(input logic [23:0] a, input logic big, input int nbusy,
                           input bit inject);
    bit ok_polls;
    int wait_c;
    fr_cnt    = 0;
    done_cnt  = 0;
    min_gap   = 1 << 30;
    sck_bad   = 0;
    busy_left = nbusy;
    @(negedge clk);
    start_i = 1'b1; addr_i = a; size64_i = big;
    @(negedge clk);
    start_i = 1'b0;
    @(negedge clk);
    chk(busy_o === 1'b1, "R6", "busy after start", busy_o, 1);
    if (inject) begin
      repeat (40) @(negedge clk);
      start_i = 1'b1; addr_i = ~a; size64_i = ~big;
      @(negedge clk);
      start_i = 1'b0;
    end
    wait_c = 0;
    while (done_cnt == 0 && wait_c < 20000) begin
      @(negedge clk);
      wait_c++;
    end
    repeat (CS_GAP + 6) @(negedge clk);
    chk(done_cnt == 1, "R6", "done pulse count", done_cnt, 1);
    chk(busy_o === 1'b0, "R6", "busy after done", busy_o, 0);
    chk(last_tout == (nbusy >= MAX_POLLS), "R7", "timeout flag",
        last_tout, nbusy >= MAX_POLLS);
    chk(fr_cnt == 2 + exp_polls(nbusy), "R5", "frame count (R10 garbage on miso)",
        fr_cnt, 2 + exp_polls(nbusy));
    chk(fr_n[0] == 8 && fr_bits[0][7:0] == 8'h06, "R2", "write-enable frame",
        fr_bits[0][7:0], 8'h06);
    chk(fr_n[1] == 32 && fr_bits[1][31:24] == exp_erase(a, big)[31:24], "R3",
        "erase opcode", fr_bits[1][31:24], exp_erase(a, big)[31:24]);
    chk(fr_bits[1][23:0] == exp_erase(a, big)[23:0], inject ? "R11" : "R4",
        "erase address", fr_bits[1][23:0], exp_erase(a, big)[23:0]);
    ok_polls = 1'b1;
    for (int i = 2; i < fr_cnt && i < 16; i++)
      if (fr_n[i] != 16 || fr_bits[i][15:8] != 8'h05) ok_polls = 1'b0;
    chk(ok_polls, "R5", "poll frame shape", ok_polls, 1);
    chk(min_gap >= CS_GAP, "R8", "cs high gap", min_gap, CS_GAP);
    chk(sck_bad == 0, "R9", "sck high time", sck_bad, 0);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    wait (cyc >= 190000);
    chk(1'b0, "ALL", "watchdog expired", cyc, 0);
    $display("%0d/%0d checks passed", n_pass, n_total);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    int unsigned seed;
    seed = 32'd2024;
    void'($urandom(seed));
    cs_rise_cyc = 0;
    rise_cyc    = 0;
    repeat (4) @(negedge clk);
    chk(cs_n_o === 1'b1 && sck_o === 1'b0, "R1", "cs/sck in reset", {cs_n_o, sck_o}, 2'b10);
    chk(busy_o === 1'b0 && done_o === 1'b0 && timeout_o === 1'b0, "R1",
        "status in reset", {busy_o, done_o, timeout_o}, 0);
    rst = 1'b0;
    repeat (CS_GAP + 2) @(negedge clk);
    // Directed corners: mask boundaries, immediate ready, timeout.
    run_erase(24'hFF_FFFF, 1'b0, 0, 1'b0);
    run_erase(24'hFF_FFFF, 1'b1, 2, 1'b0);
    run_erase(24'h00_0000, 1'b1, MAX_POLLS, 1'b0);
    run_erase(24'h00_8001, 1'b0, MAX_POLLS + 3, 1'b0);
    run_erase(24'h12_C345, 1'b0, 1, 1'b1);      // R11 start while busy
    // Random mix.
    for (int k = 0; k < 30; k++)
      run_erase(24'($urandom), 1'($urandom), int'($urandom_range(0, MAX_POLLS + 1)), 1'b0);
    $display("%0d/%0d checks passed", n_pass, n_total);
    $finish;
  end
endmodule